// File: doc/BRIEF.md
# Linear Frequency Sweep Controller for a Phase-Accumulator Synthesizer

This block owns the phase increment ("step word") that a phase-accumulator frequency synthesizer adds every clock. It raises the synthesized frequency in equal increments. The step changes only when the accumulator reports that it is about to wrap, which is the boundary between two output periods. Every frequency in the sweep therefore produces whole cycles.

The start step, increment and stop step are plain inputs. Each accepted period boundary adds the increment to the step. A result above the stop value, including a result that overflows the step width, reloads the start step and begins a new sweep. Two single-cycle strobes mark these events: one for every step change and one for every sweep restart. A downstream scope trigger or marker generator can use them. Lowering the run input holds the current step, so the sweep pauses. A phase accumulator module is included so that the controller can be tested in a closed loop.

Top module: `sweep_ctrl_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `step_word` loads `step_base`, and `freq_sync` and `sweep_sync` clear to 0. Reset is synchronous and active low.
- R2: `step_word` changes only after a rising edge at which both `wrap_stb` and `run_en` are 1. Without `wrap_stb`, it keeps its value and neither sync strobe rises.
- R3: At an accepted boundary, the unsigned sum `step_word + step_inc` is formed with one extra bit. If the sum is not above `step_limit`, the sum becomes the new `step_word`, `freq_sync` is 1 and `sweep_sync` is 0 in the next cycle.
- R4: At an accepted boundary where the sum is above `step_limit`, `step_word` reloads the present `step_base`, and both `freq_sync` and `sweep_sync` are 1 in the next cycle.
- R5: A sum that carries beyond the step width counts as above the stop value and causes a restart. It is never truncated into a small step.
- R6: While `run_en` is 0, `wrap_stb` is ignored: `step_word` is frozen and both strobes stay 0. The sweep resumes from the frozen step when `run_en` returns to 1.
- R7: Each accepted boundary gives exactly one cycle of `freq_sync`, in the same cycle that the new `step_word` appears. Accepted boundaries on consecutive cycles give one step change and one strobe per cycle.
- R8: A sum exactly equal to `step_limit` is an ordinary advance (R3), not a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Sweep enable; 0 freezes the step |
| step_base | input | STEP_W | Step word at which each sweep begins |
| step_inc | input | STEP_W | Amount added per completed period |
| step_limit | input | STEP_W | Highest step allowed before restart |
| wrap_stb | input | 1 | Accumulator wrap: high in the cycle whose next edge wraps the phase |
| step_word | output | STEP_W | Phase increment for the accumulator |
| freq_sync | output | 1 | One-cycle strobe on every step change |
| sweep_sync | output | 1 | One-cycle strobe on every sweep restart |

## Verification
All three outputs are registered directly. Any result of a `wrap_stb` sampled at one rising edge is visible from that edge on and lasts one cycle. The bench drives inputs on the falling edge and checks `step_word` and both strobes on the next falling edge, which is half a period after the update. It checks again one falling edge later to confirm that each strobe has dropped. In the closed-loop test, the bench records the accumulator wrap at each falling edge. It expects `freq_sync` at the following falling edge, and only there.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    // Decision taken at each rising edge about the step register
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_ADVANCE = 2'd1,
        ACT_RESTART = 2'd2
    } sweep_act_e;

endpackage

// File: rtl/dds_phase_accum.sv
// Phase accumulator used as the synthesizer core in closed-loop tests.
// wrap_o is the carry of the pending addition: high in the cycle whose
// next edge wraps the phase, so a step change at that edge starts the
// new period with the new step.
module dds_phase_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step_in,
    output logic [ACC_W-1:0] phase_o,
    output logic             wrap_o
);

    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, step_in};
        acc_d = sum[ACC_W-1:0];
        if (!rst_n) begin
            acc_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        acc_q <= acc_d;
    end

    assign phase_o = acc_q;
    assign wrap_o  = sum[ACC_W] & rst_n;

endmodule

// File: rtl/sweep_next_step.sv
// Candidate next step and the out-of-range test, with the carry kept.
module sweep_next_step #(
    parameter int STEP_W = 32
) (
    input  logic [STEP_W-1:0] cur_step,
    input  logic [STEP_W-1:0] inc,
    input  logic [STEP_W-1:0] limit,
    output logic [STEP_W-1:0] cand_step,
    output logic              beyond
);

    localparam int EXT_W = STEP_W + 1;

    logic [EXT_W-1:0] sum_ext;
    logic             carry;
    logic             above;

    always_comb begin
        sum_ext   = {1'b0, cur_step} + {1'b0, inc};
        carry     = sum_ext[STEP_W];
        above     = (sum_ext[STEP_W-1:0] > limit);
        cand_step = sum_ext[STEP_W-1:0];
        beyond    = carry | above;
    end

endmodule

// File: rtl/sweep_decide.sv
// Chooses hold, advance or restart for the coming edge.
module sweep_decide
    import sweep_pkg::*;
(
    input  logic       run_en,
    input  logic       wrap_stb,
    input  logic       beyond,
    output sweep_act_e act
);

    always_comb begin
        act = ACT_HOLD;
        if (run_en && wrap_stb) begin
            act = beyond ? ACT_RESTART : ACT_ADVANCE;
        end
    end

endmodule

// File: rtl/sweep_ctrl_top.sv
module sweep_ctrl_top
    import sweep_pkg::*;
#(
    parameter int STEP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [STEP_W-1:0] step_base,
    input  logic [STEP_W-1:0] step_inc,
    input  logic [STEP_W-1:0] step_limit,
    input  logic              wrap_stb,
    output logic [STEP_W-1:0] step_word,
    output logic              freq_sync,
    output logic              sweep_sync
);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              fsync;
        logic              ssync;
    } sweep_state_t;

    sweep_state_t      st_d, st_q;
    logic [STEP_W-1:0] cand_step;
    logic              beyond;
    sweep_act_e        act;

    sweep_next_step #(
        .STEP_W (STEP_W)
    ) next_i (
        .cur_step  (st_q.step),
        .inc       (step_inc),
        .limit     (step_limit),
        .cand_step (cand_step),
        .beyond    (beyond)
    );

    sweep_decide decide_i (
        .run_en   (run_en),
        .wrap_stb (wrap_stb),
        .beyond   (beyond),
        .act      (act)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fsync = 1'b0;
        st_d.ssync = 1'b0;
        case (act)
            ACT_ADVANCE: begin
                st_d.step  = cand_step;
                st_d.fsync = 1'b1;
            end
            ACT_RESTART: begin
                st_d.step  = step_base;
                st_d.fsync = 1'b1;
                st_d.ssync = 1'b1;
            end
            default: ;
        endcase
        if (!rst_n) begin
            st_d.step  = step_base;
            st_d.fsync = 1'b0;
            st_d.ssync = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign step_word  = st_q.step;
    assign freq_sync  = st_q.fsync;
    assign sweep_sync = st_q.ssync;

endmodule

// File: rtl/sweep_ctrl_chk.sv
module sweep_ctrl_chk #(
    parameter int STEP_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [STEP_W-1:0] step_base,
    input logic [STEP_W-1:0] step_inc,
    input logic [STEP_W-1:0] step_limit,
    input logic              wrap_stb,
    input logic [STEP_W-1:0] step_word,
    input logic              freq_sync,
    input logic              sweep_sync
);

    logic [STEP_W:0] ext_sum;
    logic            out_of_range;
    logic            accepted;

    assign ext_sum      = {1'b0, step_word} + {1'b0, step_inc};
    assign out_of_range = ext_sum > {1'b0, step_limit};
    assign accepted     = run_en && wrap_stb;

    // R2: no boundary, no change
    assert_no_wrap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_stb |=> $stable(step_word) && !freq_sync && !sweep_sync);

    // R6: idle freezes the sweep
    assert_idle_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(step_word) && !freq_sync && !sweep_sync);

    // R3 and R8: in-range sum (equality included) advances
    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accepted && !out_of_range |=>
            freq_sync && !sweep_sync
            && step_word == $past(step_word) + $past(step_inc));

    // R4 and R5: out-of-range or carried sum restarts at the base
    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accepted && out_of_range |=>
            freq_sync && sweep_sync && step_word == $past(step_base));

    // R7: a restart strobe never comes without the change strobe
    assert_sync_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_sync |-> freq_sync);

endmodule

bind sweep_ctrl_top sweep_ctrl_chk #(.STEP_W(STEP_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .step_base  (step_base),
    .step_inc   (step_inc),
    .step_limit (step_limit),
    .wrap_stb   (wrap_stb),
    .step_word  (step_word),
    .freq_sync  (freq_sync),
    .sweep_sync (sweep_sync)
);

// File: tb/sweep_ctrl_top_tb_top.sv
module sweep_ctrl_top_tb_top;

    localparam int STEP_W  = 32;
    localparam int CLK_PER = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_en = 1'b0;
    logic [STEP_W-1:0] step_base = '0;
    logic [STEP_W-1:0] step_inc = '0;
    logic [STEP_W-1:0] step_limit = '0;
    logic              man_wrap = 1'b0;
    logic              use_core = 1'b0;
    logic              core_wrap;
    logic              wrap_stb;
    logic [STEP_W-1:0] core_phase;
    logic [STEP_W-1:0] step_word;
    logic              freq_sync;
    logic              sweep_sync;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PER / 2) clk = ~clk;

    assign wrap_stb = use_core ? core_wrap : man_wrap;

    dds_phase_accum #(.ACC_W(STEP_W)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_in (step_word),
        .phase_o (core_phase),
        .wrap_o  (core_wrap)
    );

    sweep_ctrl_top #(.STEP_W(STEP_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .step_base  (step_base),
        .step_inc   (step_inc),
        .step_limit (step_limit),
        .wrap_stb   (wrap_stb),
        .step_word  (step_word),
        .freq_sync  (freq_sync),
        .sweep_sync (sweep_sync)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [STEP_W-1:0] s,
                             input logic f, input logic w);
        check(req, "step_word", 64'(step_word), 64'(s));
        check(req, "freq_sync", 64'(freq_sync), 64'(f));
        check(req, "sweep_sync", 64'(sweep_sync), 64'(w));
    endtask

    task automatic do_reset(input logic [STEP_W-1:0] b, input logic [STEP_W-1:0] i,
                            input logic [STEP_W-1:0] l);
        @(negedge clk);
        rst_n = 1'b0; step_base = b; step_inc = i; step_limit = l;
        man_wrap = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one accepted-or-not boundary; outputs checked on the following falling edge
    task automatic one_wrap;
        man_wrap = 1'b1;
        @(negedge clk);
        man_wrap = 1'b0;
    endtask

    task automatic t_reset;
        run_en = 1'b1;
        do_reset(32'd100, 32'd10, 32'd1000);
        check_out("R1", 32'd100, 1'b0, 1'b0);
    endtask

    task automatic t_hold_no_wrap;
        repeat (5) @(negedge clk);
        check_out("R2", 32'd100, 1'b0, 1'b0);
    endtask

    task automatic t_advance;
        one_wrap();
        check_out("R3", 32'd110, 1'b1, 1'b0);
        @(negedge clk);
        check_out("R7", 32'd110, 1'b0, 1'b0);
    endtask

    task automatic t_limit_boundary;
        do_reset(32'd100, 32'd10, 32'd120);
        one_wrap();
        check_out("R3", 32'd110, 1'b1, 1'b0);
        one_wrap();
        check_out("R8", 32'd120, 1'b1, 1'b0);
        one_wrap();
        check_out("R4", 32'd100, 1'b1, 1'b1);
        @(negedge clk);
        check_out("R7", 32'd100, 1'b0, 1'b0);
    endtask

    task automatic t_base_change_restart;
        // restart takes the base present at that edge
        step_base = 32'd105;
        one_wrap();
        check_out("R3", 32'd110, 1'b1, 1'b0);
        one_wrap();
        check_out("R8", 32'd120, 1'b1, 1'b0);
        one_wrap();
        check_out("R4", 32'd105, 1'b1, 1'b1);
    endtask

    task automatic t_freeze;
        do_reset(32'd100, 32'd10, 32'd120);
        run_en = 1'b0;
        one_wrap();
        check_out("R6", 32'd100, 1'b0, 1'b0);
        one_wrap();
        check_out("R6", 32'd100, 1'b0, 1'b0);
        run_en = 1'b1;
        one_wrap();
        check_out("R6", 32'd110, 1'b1, 1'b0);
    endtask

    task automatic t_back_to_back;
        do_reset(32'd100, 32'd10, 32'd1000);
        man_wrap = 1'b1;
        @(negedge clk);
        check_out("R7", 32'd110, 1'b1, 1'b0);
        @(negedge clk);
        man_wrap = 1'b0;
        check_out("R7", 32'd120, 1'b1, 1'b0);
        @(negedge clk);
        check_out("R7", 32'd120, 1'b0, 1'b0);
    endtask

    task automatic t_overflow;
        do_reset(32'hFFFF_FFF0, 32'h0000_0020, 32'hFFFF_FFFF);
        one_wrap();
        check_out("R5", 32'hFFFF_FFF0, 1'b1, 1'b1);
    endtask

    task automatic t_closed_loop;
        int   mism = 0;
        int   n_sync = 0;
        int   n_restart = 0;
        int   range_err = 0;
        logic prev_wrap;
        do_reset(32'd50_000_000, 32'd10_000_000, 32'd200_000_000);
        use_core = 1'b1;
        prev_wrap = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            if (freq_sync !== prev_wrap) mism++;
            if (freq_sync) n_sync++;
            if (sweep_sync) n_restart++;
            if (step_word < 32'd50_000_000 || step_word > 32'd200_000_000) range_err++;
            prev_wrap = core_wrap;
            @(negedge clk);
        end
        use_core = 1'b0;
        check("R2", "sync vs wrap mismatches", 64'(mism), 64'd0);
        check("R3", "steps outside sweep range", 64'(range_err), 64'd0);
        check("R7", "changes seen", 64'(n_sync > 20), 64'd1);
        check("R4", "restarts seen", 64'(n_restart > 0), 64'd1);
    endtask

    initial begin
        t_reset();
        t_hold_no_wrap();
        t_advance();
        t_limit_boundary();
        t_base_change_restart();
        t_freeze();
        t_back_to_back();
        t_overflow();
        t_closed_loop();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule